// File: doc/BRIEF.md
# Interrupt Event Selector and Combiner

This block sits between a population of peripheral event lines and a small set of maskable CPU interrupt inputs. Every incoming event pulse is caught in a sticky status flag that software can read and later clear. The flags are split into contiguous groups. Within each group, a per-event mask decides which flags feed an OR gate. The result is a combined event, and the four combined events take event numbers 0 to 3. Raw flags keep their own numbers from 4 upward.

Each of the twelve CPU interrupt outputs has its own selector register that holds an event number. The output follows the selected event, raw or combined, when that line's enable bit is set. Outputs are registered. Several lines may pick the same event. Selectors reset to an unused number, so every line stays quiet until software routes it. Configuration uses a single-cycle write port and a combinational read port.

Top module: `irq_event_mux`

## Requirements
- R1: After reset, all interrupt outputs are 0, all flags are 0, every mask bit is 1 (masked), the enable register is 0 and every selector reads 0x7F.
- R2: A high level on event input n (4 to 63) during a cycle sets flag n at that clock edge. Flags for events 0 to 31 read at address 0x00 and events 32 to 63 at address 0x01, at bit n mod 32.
- R3: A flag stays set until software writes a 1 to its bit at the flag address (0x00 or 0x01). The flag clears at that edge. Writing 0 to a bit leaves it unchanged.
- R4: If an event pulse and a clear write for the same flag fall in the same cycle, the flag stays set.
- R5: Event inputs 0 to 3 are ignored. Their flags always read 0.
- R6: Combined event c (0 to 3) is the OR of the flags of events 16c to 16c+15 whose mask bit is 0. Mask bits are written and read at 0x04 (events 0 to 31) and 0x05 (events 32 to 63), at bit n mod 32. A 1 masks the event.
- R7: The selector of output bit k (CPU interrupt 4+k) is at address 0x10+k, bits [6:0]. Values 0 to 3 pick a combined event, 4 to 63 pick that raw flag, and 64 to 127 keep the line at 0.
- R8: Enable bit k at address 0x08 gates output bit k. A disabled line is 0.
- R9: Each output is registered. It follows a change of flag, mask, selector or enable one clock edge after that change takes effect.
- R10: Any event can be steered to any line, and several lines may select the same event at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 64 | Peripheral event lines, one per event number |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| int_o | output | 12 | CPU interrupt lines 4 to 15, bit k is line 4+k |

## Verification
The hardest condition to reach from the ports is a clear write and a new pulse on the same flag in the same cycle. The stimulus holds the event input high across the exact cycle in which it issues the clear write, then reads the flag and watches the routed output. Combined events need the right sequence of mask writes. The bench sets up one group with one member unmasked and one masked, moves the clear and unmask between members, and checks that a mask write alone pulls a line low one edge later.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int SEL_W    = 7;

    localparam logic [ADDR_W-1:0] A_FLAG = 6'h00;
    localparam logic [ADDR_W-1:0] A_MASK = 6'h04;
    localparam logic [ADDR_W-1:0] A_ENA  = 6'h08;
    localparam logic [ADDR_W-1:0] A_SEL  = 6'h10;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_wr_t;

    // true when addr hits base + offset
    function automatic logic addr_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input int              offset);
        return addr == (base + ADDR_W'(offset));
    endfunction

endpackage

// File: rtl/irq_event_regs.sv
module irq_event_regs
    import irq_event_pkg::*;
#(
    parameter int NUM_EVT   = 64,
    parameter int NUM_LINES = 12,
    localparam int NWORDS   = NUM_EVT / DATA_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  cfg_wr_t                          wr,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_EVT-1:0]               flags,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_EVT-1:0]               clr_vec,
    output logic [NUM_EVT-1:0]               mask_q,
    output logic [NUM_LINES-1:0]             en_q,
    output logic [NUM_LINES-1:0][SEL_W-1:0]  sel_q
);

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            en_q   <= '0;
            sel_q  <= '1;
        end else if (wr.we) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (addr_hit(wr.addr, A_MASK, w))
                    mask_q[w*DATA_W +: DATA_W] <= wr.data;
            end
            if (addr_hit(wr.addr, A_ENA, 0))
                en_q <= wr.data[NUM_LINES-1:0];
            for (int k = 0; k < NUM_LINES; k++) begin
                if (addr_hit(wr.addr, A_SEL, k))
                    sel_q[k] <= wr.data[SEL_W-1:0];
            end
        end
    end

    // write-one-to-clear strobes for the flag words
    always_comb begin
        clr_vec = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (wr.we && addr_hit(wr.addr, A_FLAG, w))
                clr_vec[w*DATA_W +: DATA_W] = wr.data;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (addr_hit(rd_addr, A_FLAG, w))
                rd_data = flags[w*DATA_W +: DATA_W];
            if (addr_hit(rd_addr, A_MASK, w))
                rd_data = mask_q[w*DATA_W +: DATA_W];
        end
        if (addr_hit(rd_addr, A_ENA, 0))
            rd_data[NUM_LINES-1:0] = en_q;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (addr_hit(rd_addr, A_SEL, k))
                rd_data[SEL_W-1:0] = sel_q[k];
        end
    end

endmodule

// File: rtl/irq_event_flags.sv
module irq_event_flags #(
    parameter int NUM_EVT  = 64,
    parameter int NUM_COMB = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] clr_vec,
    output logic [NUM_EVT-1:0] flag_q
);

    // event numbers below NUM_COMB belong to the combiner, not to inputs
    localparam logic [NUM_EVT-1:0] RAW_MASK = ~(NUM_EVT'((64'd1 << NUM_COMB) - 64'd1));

    // a pulse wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else
            flag_q <= ((flag_q & ~clr_vec) | evt_i) & RAW_MASK;
    end

endmodule

// File: rtl/irq_event_combiner.sv
module irq_event_combiner #(
    parameter int NUM_EVT  = 64,
    parameter int NUM_COMB = 4,
    localparam int GRP     = NUM_EVT / NUM_COMB
) (
    input  logic [NUM_EVT-1:0]  flags,
    input  logic [NUM_EVT-1:0]  mask_q,
    output logic [NUM_COMB-1:0] comb
);

    for (genvar g = 0; g < NUM_COMB; g++) begin : g_grp
        assign comb[g] = |(flags[g*GRP +: GRP] & ~mask_q[g*GRP +: GRP]);
    end

endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
    import irq_event_pkg::*;
#(
    parameter int NUM_EVT   = 64,
    parameter int NUM_COMB  = 4,
    parameter int NUM_LINES = 12,
    localparam int NSEL     = 1 << SEL_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_EVT-1:0]              flags,
    input  logic [NUM_COMB-1:0]             comb,
    input  logic [NUM_LINES-1:0]            en_q,
    input  logic [NUM_LINES-1:0][SEL_W-1:0] sel_q,
    output logic [NUM_LINES-1:0]            int_q
);

    // event space seen by the selectors; numbers past NUM_EVT read 0
    logic [NSEL-1:0] ev_all;

    always_comb begin
        ev_all = '0;
        ev_all[NUM_EVT-1:0] = {flags[NUM_EVT-1:NUM_COMB], comb};
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                int_q[k] <= 1'b0;
            else
                int_q[k] <= en_q[k] & ev_all[sel_q[k]];
        end
    end

endmodule

// File: rtl/irq_event_mux.sv
module irq_event_mux
    import irq_event_pkg::*;
#(
    parameter int NUM_EVT   = 64,
    parameter int NUM_COMB  = 4,
    parameter int NUM_LINES = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] int_o
);

    cfg_wr_t                         wr;
    logic [NUM_EVT-1:0]              clr_vec;
    logic [NUM_EVT-1:0]              mask_q;
    logic [NUM_EVT-1:0]              flag_q;
    logic [NUM_COMB-1:0]             comb;
    logic [NUM_LINES-1:0]            en_q;
    logic [NUM_LINES-1:0][SEL_W-1:0] sel_q;

    assign wr = '{we: wr_en, addr: wr_addr, data: wr_data};

    irq_event_regs #(.NUM_EVT(NUM_EVT), .NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr), .flags(flag_q),
        .rd_data(rd_data), .clr_vec(clr_vec), .mask_q(mask_q),
        .en_q(en_q), .sel_q(sel_q)
    );

    irq_event_flags #(.NUM_EVT(NUM_EVT), .NUM_COMB(NUM_COMB)) u_flags (
        .clk(clk), .rst(rst), .evt_i(evt_i), .clr_vec(clr_vec), .flag_q(flag_q)
    );

    irq_event_combiner #(.NUM_EVT(NUM_EVT), .NUM_COMB(NUM_COMB)) u_comb (
        .flags(flag_q), .mask_q(mask_q), .comb(comb)
    );

    irq_event_router #(.NUM_EVT(NUM_EVT), .NUM_COMB(NUM_COMB),
                       .NUM_LINES(NUM_LINES)) u_route (
        .clk(clk), .rst(rst), .flags(flag_q), .comb(comb),
        .en_q(en_q), .sel_q(sel_q), .int_q(int_o)
    );

endmodule

// File: rtl/irq_event_mux_chk.sv
module irq_event_mux_chk
    import irq_event_pkg::*;
#(
    parameter int NUM_EVT   = 64,
    parameter int NUM_COMB  = 4,
    parameter int NUM_LINES = 12
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_EVT-1:0]              evt_i,
    input logic                            wr_en,
    input logic [NUM_EVT-1:0]              flags,
    input logic [NUM_LINES-1:0]            en_q,
    input logic [NUM_LINES-1:0][SEL_W-1:0] sel_q,
    input logic [NUM_LINES-1:0]            int_o
);

    localparam logic [NUM_EVT-1:0] RAW = ~(NUM_EVT'((64'd1 << NUM_COMB) - 64'd1));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (int_o == '0));

    // R2
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt_i & RAW) != '0) |=> ((($past(evt_i) & RAW) & ~flags) == '0));

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (($past(flags) & ~flags) == '0));

    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        (int_o & ~$past(en_q)) == '0);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        // R7
        unused_sel_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(sel_q[k]) >= NUM_EVT) |=> !int_o[k]);
    end

endmodule

bind irq_event_mux irq_event_mux_chk #(
    .NUM_EVT(NUM_EVT), .NUM_COMB(NUM_COMB), .NUM_LINES(NUM_LINES)
) u_chk (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .flags(flag_q),
    .en_q(en_q), .sel_q(sel_q), .int_o(int_o)
);

// File: tb/irq_event_mux_tb.sv
`timescale 1ns/100ps
module irq_event_mux_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [11:0] int_o;

    always #2.5 clk = ~clk;

    irq_event_mux u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .int_o(int_o)
    );

    typedef struct {
        int          kind;   // 0: interrupt outputs, 1: read port
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // monitor: pops and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = (it.kind == 0) ? {20'b0, int_o} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic sync();
        @(negedge clk); #0.5;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input int n);
        evt_i[n] = 1'b1;
        step();
        evt_i = '0;
    endtask

    task automatic exp_int(input logic [11:0] e, input string req);
        item_t it;
        it.kind = 0; it.exp = {20'b0, e}; it.req = req;
        q.push_back(it);
    endtask

    task automatic exp_rd(input logic [5:0] a, input logic [31:0] e, input string req);
        item_t it;
        rd_addr = a;
        it.kind = 1; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step();

        // R1 reset state
        exp_int(12'h000, "R1 outputs"); exp_rd(6'h00, 32'h0, "R1 flags"); sync();
        exp_rd(6'h04, 32'hFFFF_FFFF, "R1 masks"); sync();
        exp_rd(6'h08, 32'h0, "R1 enable"); sync();
        exp_rd(6'h10, 32'h7F, "R1 selector"); sync();

        // R2 / R9: route event 10 to line 0
        wr(6'h10, 32'd10);
        wr(6'h08, 32'h001);
        pulse(10);
        exp_int(12'h000, "R9 one edge after flag");
        exp_rd(6'h00, 32'h1 << 10, "R2 flag set"); sync();
        step();
        exp_int(12'h001, "R9 output follows"); sync();

        // R3 sticky
        repeat (5) step();
        exp_rd(6'h00, 32'h1 << 10, "R3 sticky"); exp_int(12'h001, "R3 sticky out"); sync();

        // R8 line 1 selects same event but disabled
        wr(6'h11, 32'd10);
        step();
        exp_int(12'h001, "R8 disabled line"); sync();
        wr(6'h08, 32'h003);
        exp_int(12'h001, "R9 enable latency"); sync();
        step();
        exp_int(12'h003, "R10 shared event"); sync();

        // R3 zero write, then clear
        wr(6'h00, 32'h0);
        step();
        exp_rd(6'h00, 32'h1 << 10, "R3 zero write"); sync();
        wr(6'h00, 32'h1 << 10);
        exp_rd(6'h00, 32'h0, "R3 cleared"); exp_int(12'h003, "R9 clear latency"); sync();
        step();
        exp_int(12'h000, "R3 output drops"); sync();

        // R4 pulse and clear together
        evt_i[10] = 1'b1;
        wr(6'h00, 32'h1 << 10);
        evt_i = '0;
        exp_rd(6'h00, 32'h1 << 10, "R4 pulse wins"); sync();
        step();
        exp_int(12'h003, "R4 output"); sync();
        wr(6'h00, 32'h1 << 10);
        step();

        // R5 inputs 0..3 ignored
        pulse(2);
        step();
        exp_rd(6'h00, 32'h0, "R5 low inputs"); exp_int(12'h000, "R5 out"); sync();

        // R7 unused selector value
        wr(6'h12, 32'd100);
        wr(6'h08, 32'h007);
        pulse(10);
        step();
        exp_int(12'h003, "R7 unused number"); sync();
        wr(6'h00, 32'h1 << 10);
        step(); step();

        // R6 combiner group 1 (events 16..31) on line 3
        wr(6'h13, 32'd1);
        wr(6'h08, 32'h008);
        pulse(21);
        step();
        exp_int(12'h000, "R6 masked member"); exp_rd(6'h00, 32'h1 << 21, "R2 flag 21"); sync();
        wr(6'h04, ~(32'h1 << 20));
        step();
        exp_int(12'h000, "R6 other member unmasked"); sync();
        pulse(20);
        step();
        exp_int(12'h008, "R6 unmasked member"); sync();
        wr(6'h04, ~(32'h3 << 20));
        wr(6'h00, 32'h1 << 20);
        step(); step();
        exp_int(12'h008, "R6 second member"); sync();
        wr(6'h04, 32'hFFFF_FFFF);
        exp_int(12'h008, "R9 mask latency"); sync();
        step();
        exp_int(12'h000, "R6 masked again"); sync();
        wr(6'h00, 32'h1 << 21);

        // R10 upper word event 45 on line 11
        wr(6'h1B, 32'd45);
        wr(6'h08, 32'h800);
        pulse(45);
        step();
        exp_int(12'h800, "R10 line 11"); exp_rd(6'h01, 32'h1 << 13, "R2 upper word"); sync();

        // R6 combined event 2 (events 32..47) on line 11
        wr(6'h05, ~(32'h1 << 13));
        wr(6'h1B, 32'd2);
        step();
        exp_int(12'h800, "R6 combined 2"); exp_rd(6'h05, ~(32'h1 << 13), "R6 mask readback"); sync();

        step();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule